// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit is the system-control register block beside a simple RISC core. It keeps four privileged registers: an interrupt-enable status word, a cause word, the saved return address and a faulting-address word. It also decides, on each instruction boundary the core reports, whether the core must abandon the instruction at that boundary and jump to the common handler. Two events can force the jump. An arithmetic overflow on the instruction at the boundary is a synchronous exception. A pending external request line, while interrupts are enabled, is an asynchronous interrupt.

Whichever event wins, the unit raises a redirect request in the same cycle and presents the fixed handler address. On the following clock edge it stores the boundary instruction's address as the return address and writes the reason code. It also turns interrupts off, so the handler is not entered again until software turns them back on. Software reads and writes the registers by number through a move-to/move-from port. Reads are combinational.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, registers 8, 12, 13 and 14 all read 0 while no request line is high, and no redirect is raised.
- R2: A redirect is raised only in a cycle where `boundary_i` is high. Request lines or an overflow flag with `boundary_i` low cause no redirect and change no register.
- R3: When `boundary_i` is high, Status bit 0 (interrupt enable) is 1, no overflow is flagged and any request line is high, `redirect_o` is 1 and `vector_o` is 0x80000080 in that cycle. From the next cycle, register 14 reads the `pc_i` of that cycle and the cause code (register 13 bits 5:2) is 0. In any cycle without a redirect, `vector_o` is 0.
- R4: When `boundary_i` and `ovf_i` are both high, a redirect is raised whatever the enable. Register 14 then captures `pc_i`, and the cause code becomes 12, so register 13 reads 0x30 with no request lines high.
- R5: If an overflow and an enabled pending interrupt meet at one boundary, the overflow wins and the cause code is 12.
- R6: With Status bit 0 clear, a pending request at a boundary raises no redirect.
- R7: Every taken redirect clears Status bit 0 from the next cycle on.
- R8: Register 13 bits 8 to 13 show the six request lines live (line n at bit 8+n). A move-to register 13 has no effect.
- R9: Registers are selected by number: 8 is the faulting-address word (readable and writable), 12 is Status, 13 is Cause and 14 is the return address. Only bit 0 of Status is stored; its other bits read 0. Any other number reads 0.
- R10: A move-to Status or to register 14 in the same cycle as a taken redirect is lost. The redirect's update (enable cleared, `pc_i` captured) is what remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Address of the instruction at the current boundary |
| boundary_i | input | 1 | High when the core is at an instruction boundary |
| ovf_i | input | 1 | Arithmetic overflow on the boundary instruction |
| irq_i | input | 6 | External interrupt request lines, level sensitive |
| mt_en_i | input | 1 | Move-to strobe: write `wdata_i` to register `reg_num_i` |
| reg_num_i | input | 5 | Register number for move-to and move-from |
| wdata_i | input | 32 | Move-to data |
| rdata_o | output | 32 | Move-from data of register `reg_num_i` |
| redirect_o | output | 1 | Take exception or interrupt now |
| vector_o | output | 32 | Handler address while `redirect_o` is high, else 0 |

## Verification
Software writes to Status or to the return-address register can land in the same cycle the unit takes an exception or interrupt. Those are the collisions that matter. The stimulus table issues a move-to that sets the enable, and a move-to of an unrelated value into register 14, in the very cycle a boundary triggers a redirect. Reading the registers on the following row must show the enable cleared and the boundary address stored, with the software value gone. A second overlap, an overflow meeting an enabled pending interrupt at one boundary, is judged by the cause code read back afterwards.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int          NIRQ     = 6,
  parameter logic [31:0] VECTOR   = 32'h8000_0080,
  parameter logic [3:0]  OVF_CODE = 4'd12,
  parameter logic [3:0]  IRQ_CODE = 4'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      pc_i,
  input  logic             boundary_i,
  input  logic             ovf_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             mt_en_i,
  input  logic [4:0]       reg_num_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             redirect_o,
  output logic [31:0]      vector_o
);
  localparam logic [4:0] N_BADVA  = 5'd8;
  localparam logic [4:0] N_STATUS = 5'd12;
  localparam logic [4:0] N_CAUSE  = 5'd13;
  localparam logic [4:0] N_EPC    = 5'd14;
  localparam int         PEND_LSB = 8;

  logic        ie;
  logic [3:0]  code;
  logic [31:0] epc;
  logic [31:0] badva;

  wire take_exc = boundary_i & ovf_i;
  wire take_irq = boundary_i & ~ovf_i & ie & (|irq_i);
  wire take     = take_exc | take_irq;

  wire wr_status = mt_en_i && (reg_num_i == N_STATUS);
  wire wr_epc    = mt_en_i && (reg_num_i == N_EPC);
  wire wr_badva  = mt_en_i && (reg_num_i == N_BADVA);

  assign redirect_o = take;
  assign vector_o   = take ? VECTOR : 32'h0;

  wire [31:0] pend_word  = {{(32-NIRQ){1'b0}}, irq_i} << PEND_LSB;
  wire [31:0] cause_word = pend_word | {26'h0, code, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie    <= 1'b0;
      code  <= 4'h0;
      epc   <= 32'h0;
      badva <= 32'h0;
    end else begin
      if (take) begin
        ie   <= 1'b0;
        code <= take_exc ? OVF_CODE : IRQ_CODE;
        epc  <= pc_i;
      end else begin
        if (wr_status) ie  <= wdata_i[0];
        if (wr_epc)    epc <= wdata_i;
      end
      if (wr_badva) badva <= wdata_i;
    end
  end

  always_comb begin
    case (reg_num_i)
      N_BADVA:  rdata_o = badva;
      N_STATUS: rdata_o = {31'h0, ie};
      N_CAUSE:  rdata_o = cause_word;
      N_EPC:    rdata_o = epc;
      default:  rdata_o = 32'h0;
    endcase
  end

  p_redirect_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> boundary_i);
  p_vector_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (vector_o == VECTOR));
  p_epc_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> (epc == $past(pc_i)));
  p_ovf_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && ovf_i) |=> (code == OVF_CODE));
  p_enable_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !ie);
  p_no_irq_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !ovf_i && !ie) |-> !redirect_o);
endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0;
  logic        boundary_i = 1'b0;
  logic        ovf_i = 1'b0;
  logic [5:0]  irq_i = '0;
  logic        mt_en_i = 1'b0;
  logic [4:0]  reg_num_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        redirect_o;
  logic [31:0] vector_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_ctrl i_exc_ctrl (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .boundary_i(boundary_i),
    .ovf_i(ovf_i), .irq_i(irq_i), .mt_en_i(mt_en_i), .reg_num_i(reg_num_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .redirect_o(redirect_o),
    .vector_o(vector_o)
  );

  // row: move-to, reg number, write data, boundary, overflow, irq, pc,
  //      expected redirect, expected read data (state before this edge)
  function automatic logic [110:0] row(logic mt, logic [4:0] n, logic [31:0] wd,
      logic b, logic o, logic [5:0] q, logic [31:0] pc, logic r, logic [31:0] rd);
    return {mt, n, wd, b, o, q, pc, r, rd};
  endfunction

  localparam int NV = 33;
  localparam logic [110:0] VEC [NV] = '{
    row(0,12,0,          0,0,6'h00,0,      0,32'h0),     // R1 status
    row(0,13,0,          0,0,6'h01,0,      0,32'h100),   // R8 line 0 shown
    row(1,12,32'hFFFFFFFF,0,0,6'h00,0,     0,32'h0),     // R9 set enable
    row(0,12,0,          0,0,6'h00,0,      0,32'h1),     // R9 only bit 0
    row(0,14,0,          1,0,6'h00,32'h400,0,32'h0),     // R3 no request
    row(0,14,0,          1,0,6'h04,32'h404,1,32'h0),     // R3 interrupt taken
    row(0,14,0,          0,0,6'h00,0,      0,32'h404),   // R3 epc
    row(0,13,0,          0,0,6'h00,0,      0,32'h0),     // R3 code 0
    row(0,12,0,          0,0,6'h00,0,      0,32'h0),     // R7 enable cleared
    row(0,13,0,          1,0,6'h01,32'h408,0,32'h100),   // R6 gated
    row(0,13,0,          1,1,6'h00,32'h40C,1,32'h0),     // R4 overflow
    row(0,13,0,          0,0,6'h00,0,      0,32'h30),    // R4 code 12
    row(0,14,0,          0,0,6'h00,0,      0,32'h40C),   // R4 epc
    row(1,13,32'hFFFFFFFF,0,0,6'h00,0,     0,32'h30),    // R8 write cause
    row(0,13,0,          0,0,6'h00,0,      0,32'h30),    // R8 ignored
    row(1,12,1,          0,0,6'h00,0,      0,32'h0),     // R5 enable
    row(0,12,0,          1,1,6'h20,32'h500,1,32'h1),     // R5 both pending
    row(0,13,0,          0,0,6'h00,0,      0,32'h30),    // R5 overflow wins
    row(1,12,1,          0,0,6'h00,0,      0,32'h0),     // R10 enable
    row(1,14,32'hABC,    1,0,6'h01,32'h600,1,32'h500),   // R10 epc clash
    row(0,14,0,          0,0,6'h00,0,      0,32'h600),   // R10 capture wins
    row(1,12,1,          1,1,6'h00,32'h700,1,32'h0),     // R10 status clash
    row(0,12,0,          0,0,6'h00,0,      0,32'h0),     // R10 clear wins
    row(1,8,32'h1234,    0,0,6'h00,0,      0,32'h0),     // R9 badva write
    row(0,8,0,           0,0,6'h00,0,      0,32'h1234),  // R9 badva read
    row(0,9,0,           0,0,6'h00,0,      0,32'h0),     // R9 unused number
    row(0,13,0,          0,0,6'h3F,0,      0,32'h3F30),  // R8 all lines
    row(1,12,1,          0,0,6'h00,0,      0,32'h0),     // R2 enable
    row(0,12,0,          0,0,6'h01,32'h800,0,32'h1),     // R2 no boundary
    row(0,12,0,          0,1,6'h01,32'h804,0,32'h1),     // R2 ovf no boundary
    row(0,14,0,          0,0,6'h00,0,      0,32'h700),   // R2 epc untouched
    row(0,12,0,          0,0,6'h00,0,      0,32'h1),     // R2 enable kept
    row(0,13,0,          0,0,6'h00,0,      0,32'h30)     // R2 code kept
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(string req, logic [4:0] n, logic [31:0] exp);
    @(negedge clk);
    mt_en_i = 0; boundary_i = 0; ovf_i = 0; irq_i = 0; reg_num_i = n;
    #1 chk(req, rdata_o, exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    rd_reg("R1 badva", 5'd8, 32'h0);
    rd_reg("R1 status", 5'd12, 32'h0);
    rd_reg("R1 cause", 5'd13, 32'h0);
    rd_reg("R1 epc", 5'd14, 32'h0);
    chk("R1 redirect", {31'h0, redirect_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [110:0] v;
      v = VEC[i];
      @(negedge clk);
      mt_en_i = v[110]; reg_num_i = v[109:105]; wdata_i = v[104:73];
      boundary_i = v[72]; ovf_i = v[71]; irq_i = v[70:65]; pc_i = v[64:33];
      #1;
      chk($sformatf("R2/R3 row %0d redirect", i), {31'h0, redirect_o}, {31'h0, v[32]});
      chk($sformatf("R3 row %0d vector", i), vector_o, v[32] ? 32'h8000_0080 : 32'h0);
      chk($sformatf("R9 row %0d read", i), rdata_o, v[31:0]);
    end

    // R1 reset mid-run clears everything
    @(negedge clk);
    mt_en_i = 0; boundary_i = 0; ovf_i = 0;
    rst_n = 1'b0;
    #1 rst_n = 1'b1;
    rd_reg("R1 epc after reset", 5'd14, 32'h0);
    rd_reg("R1 cause after reset", 5'd13, 32'h0);
    rd_reg("R1 badva after reset", 5'd8, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule